// File: doc/BRIEF.md
# Bridge Control Register File

This block is a bank of 32-bit control registers that a host bridge exposes to software through a plain word-wide read/write strobe port. Each access carries a byte offset; its upper bits select one of 28 word registers and its two lowest bits are ignored, because only full-word accesses exist. Most registers simply keep what is written to them and come out of reset with fixed values.

Three registers behave differently. The interrupt enable mask cannot be written directly. It changes only through two alias registers. Writing the set alias ORs the written bits into the mask, and writing the clear alias removes them. The enable mask and the interrupt status word are both read-only. The general configuration register also drives a soft-reset request: a write that takes its bit 2 from 0 to 1 produces a one-cycle pulse. The system logic around the bank uses that pulse to start a reset.

Reads are registered. Data and a valid flag appear in the cycle after the read strobe. Offsets past the end of the bank are silent: writes there are dropped and reads there return zero.

Top module: `bcr_regfile`

## Requirements
- R1: After reset, word indices hold these values: 0 = 0x00000C40, 1 = 0x00001384, 2 = 0x2BFF8010, 3 = 0x255E0091, 4 = 0x00006140, 7 = 0x000001FF, 8 = 0x000001FF, 26 = 0x00000008, 27 = 0x10000000. Every other index reads 0. The soft-reset request and read-valid are low.
- R2: A write to a plain register (every in-range index except 14 and 15) stores the full 32-bit write data. A later read at the same offset returns it.
- R3: Read data and read-valid change in the cycle after the read strobe. Read-valid is high for exactly that one cycle. If a read and a write hit the same register in the same cycle, the read returns the value from before the write.
- R4: A write to offset 0x30 (index 12) stores the data there and ORs it into the enable mask at offset 0x38 (index 14).
- R5: A write to offset 0x34 (index 13) stores the data there and clears, in the enable mask, every bit that is 1 in the data.
- R6: Writes to offset 0x38 (enable mask) and offset 0x3C (interrupt status, always 0) change nothing.
- R7: A write to offset 0x04 whose data has bit 2 set, while the stored bit 2 is 0, raises the soft-reset request in the next cycle for exactly one cycle.
- R8: A write to offset 0x04 while the stored bit 2 is already 1 raises no request, whatever the data.
- R9: Offsets 0x70 and above, which are word indices of 28 and more, ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, held between reads |
| rvalid | output | 1 | High in the cycle after a read strobe |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
A corrupted stored word shows up on rdata exactly one cycle after the read strobe that selects it. The directed reads therefore cover every index, including indices of 28 and more. The enable mask is hidden state that changes through side effects, so it is read back after every alias write. A stale or doubled update in the mask shows up at the first such read. A wrong copy of the configuration bit shows up as a missing, extra or stretched pulse in the single cycle that follows a write to offset 0x04.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    localparam int DATA_W      = 32;
    localparam int NREG        = 28;
    localparam int IDX_GEN     = 1;
    localparam int IDX_EN_SET  = 12;
    localparam int IDX_EN_CLR  = 13;
    localparam int IDX_EN      = 14;
    localparam int IDX_STAT    = 15;
    localparam int GEN_RST_BIT = 2;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        KIND_RW,
        KIND_ENABLE,
        KIND_STATUS
    } reg_kind_e;

    function automatic reg_kind_e kind_of(input int i);
        if (i == IDX_EN)   return KIND_ENABLE;
        if (i == IDX_STAT) return KIND_STATUS;
        return KIND_RW;
    endfunction

    function automatic word_t reset_value(input int i);
        case (i)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7:       return 32'h0000_01FF;
            8:       return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/bcr_wr_decode.sv
module bcr_wr_decode
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   we,
    output logic              set_hit,
    output logic              clr_hit,
    output logic              gen_hit
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:2];

    for (genvar i = 0; i < NREG; i++) begin : g_we
        if (kind_of(i) == KIND_RW) begin : g_rw
            assign we[i] = wr_en && (idx == IDX_W'(i));
        end else begin : g_ro
            assign we[i] = 1'b0;
        end
    end

    assign set_hit = wr_en && (idx == IDX_W'(IDX_EN_SET));
    assign clr_hit = wr_en && (idx == IDX_W'(IDX_EN_CLR));
    assign gen_hit = wr_en && (idx == IDX_W'(IDX_GEN));

endmodule

// File: rtl/bcr_bank.sv
module bcr_bank
    import bcr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NREG-1:0]             we,
    input  logic                        set_hit,
    input  logic                        clr_hit,
    input  word_t                       wdata,
    output logic [NREG-1:0][DATA_W-1:0] q
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (kind_of(i) == KIND_RW) begin : g_rw
            word_t r;
            always_ff @(posedge clk) begin
                if (rst)        r <= reset_value(i);
                else if (we[i]) r <= wdata;
            end
            assign q[i] = r;

            p_store_r2: assert property (@(posedge clk) disable iff (rst)
                we[i] |=> (r == $past(wdata)));
        end else if (kind_of(i) == KIND_ENABLE) begin : g_en
            word_t r;
            always_ff @(posedge clk) begin
                if (rst)          r <= reset_value(i);
                else if (set_hit) r <= r | wdata;
                else if (clr_hit) r <= r & ~wdata;
            end
            assign q[i] = r;

            p_set_or_r4: assert property (@(posedge clk) disable iff (rst)
                set_hit |=> ((r & $past(wdata)) == $past(wdata)));
            p_clr_and_r5: assert property (@(posedge clk) disable iff (rst)
                clr_hit |=> ((r & $past(wdata)) == '0));
            p_en_hold_r6: assert property (@(posedge clk) disable iff (rst)
                (!set_hit && !clr_hit) |=> $stable(r));
        end else begin : g_stat
            assign q[i] = reset_value(i);
        end
    end

endmodule

// File: rtl/bcr_rst_pulse.sv
module bcr_rst_pulse #(
    parameter int BIT_SEL = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gen_hit,
    input  logic new_bit,
    input  logic cur_bit,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= gen_hit && new_bit && !cur_bit;
    end

    p_req_single_r7: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);
    p_req_cause_r7: assert property (@(posedge clk) disable iff (rst)
        req |-> ($past(gen_hit) && $past(new_bit)));
    p_no_repeat_r8: assert property (@(posedge clk) disable iff (rst)
        (gen_hit && cur_bit) |=> !req);

endmodule

// File: rtl/bcr_rd_port.sv
module bcr_rd_port
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NREG-1:0][DATA_W-1:0] q,
    output word_t                       rdata,
    output logic                        rvalid
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             in_range;
    word_t            sel;

    assign idx      = addr[ADDR_W-1:2];
    assign in_range = (int'(idx) < NREG);

    always_comb begin
        sel = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IDX_W'(i)) sel = q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= in_range ? sel : '0;
        end
    end

    p_rvalid_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);
    p_rvalid_low_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rvalid);
    p_oob_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !in_range) |=> (rdata == '0));

endmodule

// File: rtl/bcr_regfile.sv
module bcr_regfile
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid,
    output logic              soft_rst_req
);
    logic [NREG-1:0]             we;
    logic                        set_hit;
    logic                        clr_hit;
    logic                        gen_hit;
    logic [NREG-1:0][DATA_W-1:0] q;

    bcr_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .we      (we),
        .set_hit (set_hit),
        .clr_hit (clr_hit),
        .gen_hit (gen_hit)
    );

    bcr_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .set_hit (set_hit),
        .clr_hit (clr_hit),
        .wdata   (wdata),
        .q       (q)
    );

    bcr_rst_pulse #(.BIT_SEL(GEN_RST_BIT)) u_req (
        .clk     (clk),
        .rst     (rst),
        .gen_hit (gen_hit),
        .new_bit (wdata[GEN_RST_BIT]),
        .cur_bit (q[IDX_GEN][GEN_RST_BIT]),
        .req     (soft_rst_req)
    );

    bcr_rd_port #(.ADDR_W(ADDR_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .addr   (addr),
        .q      (q),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    p_req_after_gen_r7: assert property (@(posedge clk) disable iff (rst)
        soft_rst_req |-> $past(gen_hit));

endmodule

// File: tb/bcr_regfile_tb.sv
module bcr_regfile_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        soft_rst_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bcr_regfile u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .rvalid       (rvalid),
        .soft_rst_req (soft_rst_req)
    );

    function automatic logic [31:0] exp_reset(input int i);
        case (i)
            0:  return 32'h0000_0C40;
            1:  return 32'h0000_1384;
            2:  return 32'h2BFF_8010;
            3:  return 32'h255E_0091;
            4:  return 32'h0000_6140;
            7:  return 32'h0000_01FF;
            8:  return 32'h0000_01FF;
            26: return 32'h0000_0008;
            27: return 32'h1000_0000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, output logic pulse);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        pulse = soft_rst_req;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, {31'b0, rvalid}, 32'h1);
        check(req, rdata, exp);
    endtask

    task automatic t_reset;
        check("R1 req", {31'b0, soft_rst_req}, 32'h0);
        check("R1 rvalid", {31'b0, rvalid}, 32'h0);
        for (int i = 0; i < 28; i++) rd_check("R1", 8'(i * 4), exp_reset(i));
    endtask

    task automatic t_plain;
        logic p;
        do_write(8'h00, 32'hDEAD_BEEF, p); rd_check("R2", 8'h00, 32'hDEAD_BEEF);
        do_write(8'h14, 32'h1234_5678, p); rd_check("R2", 8'h14, 32'h1234_5678);
        do_write(8'h42, 32'hA5A5_5A5A, p); rd_check("R2", 8'h40, 32'hA5A5_5A5A);
        do_write(8'h6C, 32'hFFFF_FFFF, p); rd_check("R2", 8'h6C, 32'hFFFF_FFFF);
        do_write(8'h6C, 32'h0, p);         rd_check("R2", 8'h6C, 32'h0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        check("R3 idle", {31'b0, rvalid}, 32'h0);
        rd_en = 1'b1; wr_en = 1'b1; addr = 8'h14; wdata = 32'hCAFE_0001;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R3 valid", {31'b0, rvalid}, 32'h1);
        check("R3 old", rdata, 32'h1234_5678);
        @(negedge clk);
        check("R3 one-cycle", {31'b0, rvalid}, 32'h0);
        check("R3 hold", rdata, 32'h1234_5678);
        rd_check("R3 new", 8'h14, 32'hCAFE_0001);
    endtask

    task automatic t_set;
        logic p;
        do_write(8'h30, 32'h0000_00F0, p);
        rd_check("R4 alias", 8'h30, 32'h0000_00F0);
        rd_check("R4 mask", 8'h38, 32'h0000_00F0);
        do_write(8'h30, 32'h0000_0F00, p);
        rd_check("R4 mask or", 8'h38, 32'h0000_0FF0);
    endtask

    task automatic t_clr;
        logic p;
        do_write(8'h34, 32'h0000_0030, p);
        rd_check("R5 alias", 8'h34, 32'h0000_0030);
        rd_check("R5 mask", 8'h38, 32'h0000_0FC0);
        rd_check("R5 set alias kept", 8'h30, 32'h0000_0F00);
    endtask

    task automatic t_ro;
        logic p;
        do_write(8'h38, 32'hFFFF_FFFF, p);
        rd_check("R6 mask", 8'h38, 32'h0000_0FC0);
        do_write(8'h3C, 32'hFFFF_FFFF, p);
        rd_check("R6 status", 8'h3C, 32'h0);
    endtask

    task automatic t_rst_req;
        logic p;
        do_write(8'h04, 32'h0000_1384, p);
        check("R8 already set", {31'b0, p}, 32'h0);
        do_write(8'h04, 32'h0000_1380, p);
        check("R8 clear bit", {31'b0, p}, 32'h0);
        do_write(8'h04, 32'h0000_1384, p);
        check("R7 pulse", {31'b0, p}, 32'h1);
        @(negedge clk);
        check("R7 single", {31'b0, soft_rst_req}, 32'h0);
        do_write(8'h04, 32'hFFFF_FFFF, p);
        check("R8 again", {31'b0, p}, 32'h0);
        rd_check("R7 stored", 8'h04, 32'hFFFF_FFFF);
    endtask

    task automatic t_oob;
        logic p;
        do_write(8'h70, 32'h5555_AAAA, p);
        do_write(8'hFC, 32'h5555_AAAA, p);
        rd_check("R9 0x70", 8'h70, 32'h0);
        rd_check("R9 0xFC", 8'hFC, 32'h0);
        rd_check("R9 idx0 intact", 8'h00, 32'hDEAD_BEEF);
        rd_check("R9 idx12 intact", 8'h30, 32'h0000_0F00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_plain;
        t_latency;
        t_set;
        t_clr;
        t_ro;
        t_rst_req;
        t_oob;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule